// File: doc/BRIEF.md
# PIPE Lane Rate Switch Sequencer

This block steps one PCIe PHY lane from one signaling generation to another when the MAC asks for it. It watches a 2-bit rate request. When the request names a legal rate that differs from the one in use, it runs a fixed ordered sequence. It waits for the transmit FIFO to drain and then holds the PCS in reset. It gates the clocks of both PCS datapaths and moves the 8.0 Gbps clock/data multiplexer only when that rate is involved. It then asks the PMA for the new rate and waits until the PMA echoes it back. After that it undoes the steps in reverse order, a fixed settle interval apart, and ends with a one-cycle PHY status pulse.

In a bonded group, one lane is strapped as master. The master publishes its target rate to the other lanes. A follower lane takes its request from that published rate instead of from the MAC.

Top module: `pipe_rate_seq`

## Requirements
- R1: The rate code is 2'b00 for 2.5 Gbps, 2'b01 for 5.0 Gbps and 2'b10 for 8.0 Gbps. `pma_sw` carries the code of the rate being entered and changes only while the PCS clocks are gated. The sequence does not move past the PMA request until `pma_sw_done` equals `pma_sw`.
- R2: `pcs_rst` rises only on a cycle after `txfifo_empty` was seen high.
- R3: `pcs_clk_off` is high only while `pcs_rst` is high. It is raised after reset and dropped before reset is released.
- R4: `g3_sel` changes only in a switch whose old or new rate is 2'b10. After any switch it is 1 exactly when the current rate is 2'b10.
- R5: `pcs_rst` falls SETTLE cycles after `pcs_clk_off` falls, and `phy_status` pulses SETTLE cycles after `pcs_rst` falls. SETTLE is at least 4.
- R6: `phy_status` is high for exactly one cycle per completed switch, with reset and clock gating both released.
- R7: A request equal to the current rate, or the code 2'b11, starts no sequence and leaves every output unchanged.
- R8: A request that changes while a switch is in progress is not lost. Once the block is idle again, a pending request that differs from the current rate starts a new switch.
- R9: With `bond_en` high and `bond_is_master` high, `bond_rate_out` shows the lane's target rate. With `bond_en` high and `bond_is_master` low, the lane takes its request from `bond_rate_in` and ignores `mac_rate`. Without `bond_en`, `bond_rate_out` is 2'b00.
- R10: After reset, `pcs_rst`, `pcs_clk_off`, `g3_sel` and `phy_status` are 0, and `pma_sw` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PIPE interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_rate | input | 2 | Rate requested by the MAC |
| txfifo_empty | input | 1 | Transmit FIFO has been flushed |
| pma_sw_done | input | 2 | Rate code confirmed by the PMA |
| bond_en | input | 1 | Lane is part of a bonded group |
| bond_is_master | input | 1 | Lane is the master of its group |
| bond_rate_in | input | 2 | Target rate published by the master |
| pcs_rst | output | 1 | Reset to both PCS datapaths |
| pcs_clk_off | output | 1 | Clock gate to both PCS datapaths |
| g3_sel | output | 1 | Clock and data mux select for the 8.0 Gbps PCS |
| pma_sw | output | 2 | Rate switch request to the PMA |
| phy_status | output | 1 | One-cycle switch completion pulse |
| bond_rate_out | output | 2 | Target rate published to follower lanes |

## Verification
The assertions assume that the PMA echoes on `pma_sw_done` only a code it was given on `pma_sw`. They also assume that `txfifo_empty`, once high during a flush wait, stays high until reset is asserted. The bench PMA model delays `pma_sw` by a few registers, and it can freeze to stretch the wait. The FIFO flag is dropped only before a request is made and is raised once, after a chosen lag, so both assumptions hold for every stimulus.

// File: rtl/pipe_rate_seq.sv
module pipe_rate_seq #(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mac_rate,
  input  logic       txfifo_empty,
  input  logic [1:0] pma_sw_done,
  input  logic       bond_en,
  input  logic       bond_is_master,
  input  logic [1:0] bond_rate_in,
  output logic       pcs_rst,
  output logic       pcs_clk_off,
  output logic       g3_sel,
  output logic [1:0] pma_sw,
  output logic       phy_status,
  output logic [1:0] bond_rate_out
);
  localparam int SET_N = (SETTLE < 4) ? 4 : SETTLE;
  localparam int CW    = $clog2(SET_N + 1);
  localparam logic [1:0] GEN3 = 2'b10;
  localparam logic [1:0] RSVD = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_FLUSH, S_GATE, S_MUX, S_REQ, S_WAIT, S_RCLK, S_RRST, S_DONE
  } st_t;

  st_t         st;
  logic [1:0]  cur, target;
  logic [CW-1:0] cnt;

  wire         follower = bond_en & ~bond_is_master;
  wire [1:0]   req      = follower ? bond_rate_in : mac_rate;
  wire         go       = (req != RSVD) && (req != cur);
  wire         settled  = (cnt == CW'(SET_N - 1));
  wire         g3_move  = (target == GEN3) || (cur == GEN3);

  assign bond_rate_out = (bond_en & bond_is_master) ? target : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur         <= 2'b00;
      target      <= 2'b00;
      cnt         <= '0;
      pcs_rst     <= 1'b0;
      pcs_clk_off <= 1'b0;
      g3_sel      <= 1'b0;
      pma_sw      <= 2'b00;
      phy_status  <= 1'b0;
    end else begin
      phy_status <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          target <= req;
          st     <= S_FLUSH;
        end
        S_FLUSH: if (txfifo_empty) begin
          pcs_rst <= 1'b1;
          st      <= S_GATE;
        end
        S_GATE: begin
          pcs_clk_off <= 1'b1;
          st          <= S_MUX;
        end
        S_MUX: begin
          if (g3_move) g3_sel <= (target == GEN3);
          st <= S_REQ;
        end
        S_REQ: begin
          pma_sw <= target;
          st     <= S_WAIT;
        end
        S_WAIT: if (pma_sw_done == pma_sw) begin
          cnt <= '0;
          st  <= S_RCLK;
        end
        S_RCLK: begin
          cnt <= cnt + 1'b1;
          if (settled) begin
            pcs_clk_off <= 1'b0;
            cnt         <= '0;
            st          <= S_RRST;
          end
        end
        S_RRST: begin
          cnt <= cnt + 1'b1;
          if (settled) begin
            pcs_rst <= 1'b0;
            cnt     <= '0;
            st      <= S_DONE;
          end
        end
        S_DONE: begin
          cnt <= cnt + 1'b1;
          if (settled) begin
            phy_status <= 1'b1;
            cur        <= target;
            cnt        <= '0;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pipe_rate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txfifo_empty,
  input logic       pcs_rst,
  input logic       pcs_clk_off,
  input logic       g3_sel,
  input logic [1:0] pma_sw,
  input logic       phy_status
);
  a_r3_gate_inside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_clk_off |-> pcs_rst);

  a_r2_reset_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcs_rst) |-> $past(txfifo_empty));

  a_r1_pma_req_while_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pma_sw) |-> pcs_clk_off);

  a_r4_mux_while_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(g3_sel) |-> (pcs_clk_off && pcs_rst));

  a_r6_status_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    phy_status |=> !phy_status);

  a_r6_status_released: assert property (@(posedge clk) disable iff (!rst_n)
    phy_status |-> (!pcs_rst && !pcs_clk_off));

  a_r5_clock_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcs_rst) |-> !pcs_clk_off);
endmodule

bind pipe_rate_seq pipe_rate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txfifo_empty(txfifo_empty), .pcs_rst(pcs_rst),
  .pcs_clk_off(pcs_clk_off), .g3_sel(g3_sel), .pma_sw(pma_sw),
  .phy_status(phy_status)
);

// File: tb/sim_pipe_rate_seq.sv
module sim_pipe_rate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SET = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mac_rate = 2'b00, bond_rate_in = 2'b00;
  logic txfifo_empty = 1'b1, bond_en = 1'b0, bond_is_master = 1'b0;
  logic [1:0] pma_sw_done;
  logic pcs_rst, pcs_clk_off, g3_sel, phy_status;
  logic [1:0] pma_sw, bond_rate_out;

  int checks = 0, fails = 0, cyc = 0;
  logic [1:0] model_rate = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_rate_seq #(.SETTLE(SET)) u0 (
    .clk(clk), .rst_n(rst_n), .mac_rate(mac_rate), .txfifo_empty(txfifo_empty),
    .pma_sw_done(pma_sw_done), .bond_en(bond_en), .bond_is_master(bond_is_master),
    .bond_rate_in(bond_rate_in), .pcs_rst(pcs_rst), .pcs_clk_off(pcs_clk_off),
    .g3_sel(g3_sel), .pma_sw(pma_sw), .phy_status(phy_status),
    .bond_rate_out(bond_rate_out)
  );

  logic pma_stall = 1'b0;
  logic [1:0] p1 = 2'b00, p2 = 2'b00, p3 = 2'b00;
  always @(posedge clk) if (!pma_stall) begin
    p1 <= pma_sw; p2 <= p1; p3 <= p2;
  end
  assign pma_sw_done = p3;

  int n_status = 0, n_g3 = 0, n_flushbad = 0;
  int t_clk_fall = 0, t_rst_fall = 0, t_status = 0;
  logic pv_clk = 1'b0, pv_rst = 1'b0, pv_g3 = 1'b0, pv_empty = 1'b1;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (phy_status) begin n_status <= n_status + 1; t_status <= cyc; end
    if (pv_clk && !pcs_clk_off) t_clk_fall <= cyc;
    if (pv_rst && !pcs_rst) t_rst_fall <= cyc;
    if (!pv_rst && pcs_rst && !pv_empty) n_flushbad <= n_flushbad + 1;
    if (pv_g3 != g3_sel) n_g3 <= n_g3 + 1;
    pv_clk <= pcs_clk_off; pv_rst <= pcs_rst; pv_g3 <= g3_sel; pv_empty <= txfifo_empty;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {req[1:0], flush_lag[3:0]}
  localparam logic [5:0] VEC [9] = '{
    {2'b01, 4'd0}, {2'b10, 4'd3}, {2'b10, 4'd0}, {2'b11, 4'd0}, {2'b00, 4'd5},
    {2'b11, 4'd2}, {2'b10, 4'd1}, {2'b01, 4'd0}, {2'b00, 4'd7}
  };

  task automatic run_switch(input logic [1:0] req, input int lag);
    int s0, g0, f0;
    logic [1:0] sw0;
    bit sw, g3x;
    s0 = n_status; g0 = n_g3; f0 = n_flushbad; sw0 = pma_sw;
    sw  = (req != 2'b11) && (req != model_rate);
    g3x = sw && ((req == 2'b10) || (model_rate == 2'b10));
    if (lag > 0) txfifo_empty = 1'b0;
    mac_rate = req;
    cycles(lag);
    txfifo_empty = 1'b1;
    cycles(60);
    if (sw) begin
      check(n_status - s0 == 1, "R6 one status pulse", n_status - s0, 1);
      check(pma_sw == req, "R1 pma_sw rate", pma_sw, req);
      check(g3_sel == (req == 2'b10), "R4 g3_sel level", g3_sel, req == 2'b10);
      check(n_g3 - g0 == int'(g3x), "R4 g3_sel toggles", n_g3 - g0, int'(g3x));
      check(t_rst_fall - t_clk_fall == SET, "R5 clock-to-reset gap", t_rst_fall - t_clk_fall, SET);
      check(t_status - t_rst_fall == SET, "R5 reset-to-status gap", t_status - t_rst_fall, SET);
      check(n_flushbad == f0, "R2 reset before flush", n_flushbad - f0, 0);
      model_rate = req;
    end else begin
      check(n_status == s0, "R7 no status", n_status - s0, 0);
      check(pma_sw == sw0, "R7 pma_sw unchanged", pma_sw, sw0);
      check(!pcs_rst && !pcs_clk_off, "R7 no reset", pcs_rst, 0);
      check(n_g3 == g0, "R7 g3_sel unchanged", n_g3 - g0, 0);
    end
  endtask

  initial begin
    int s0;
    cycles(3);
    check(!pcs_rst && !pcs_clk_off && !g3_sel && !phy_status, "R10 reset outputs",
          {pcs_rst, pcs_clk_off, g3_sel, phy_status}, 0);
    check(pma_sw == 2'b00, "R10 pma_sw reset", pma_sw, 0);
    rst_n = 1'b1;
    cycles(2);

    foreach (VEC[i]) run_switch(VEC[i][5:4], int'(VEC[i][3:0]));

    // R1: no completion while PMA has not confirmed
    pma_stall = 1'b1;
    s0 = n_status;
    mac_rate = 2'b01;
    cycles(30);
    check(pcs_clk_off && pcs_rst, "R1 held gated while waiting", pcs_clk_off, 1);
    check(pma_sw == 2'b01, "R1 request presented", pma_sw, 1);
    check(n_status == s0, "R1 no status before done", n_status - s0, 0);
    // R8: request changed mid-switch is served afterwards
    mac_rate = 2'b10;
    cycles(5);
    pma_stall = 1'b0;
    cycles(120);
    check(n_status - s0 == 2, "R8 two switches", n_status - s0, 2);
    check(pma_sw == 2'b10 && g3_sel, "R8 final rate", pma_sw, 2);
    model_rate = 2'b10;

    // R9: master publishes target
    bond_en = 1'b1; bond_is_master = 1'b1;
    mac_rate = 2'b00;
    cycles(3);
    check(bond_rate_out == 2'b00, "R9 master target out", bond_rate_out, 0);
    cycles(60);
    model_rate = 2'b00;
    mac_rate = 2'b01;
    cycles(60);
    check(bond_rate_out == 2'b01 && pma_sw == 2'b01, "R9 master after switch", bond_rate_out, 1);
    model_rate = 2'b01;
    // R9: follower ignores mac_rate
    bond_is_master = 1'b0;
    bond_rate_in = 2'b01;
    mac_rate = 2'b10;
    s0 = n_status;
    cycles(60);
    check(n_status == s0 && pma_sw == 2'b01, "R9 follower ignores mac", pma_sw, 1);
    bond_rate_in = 2'b00;
    cycles(60);
    check(pma_sw == 2'b00 && n_status - s0 == 1, "R9 follower tracks master", pma_sw, 0);
    check(bond_rate_out == 2'b00, "R9 follower out idle", bond_rate_out, 0);
    bond_en = 1'b0;
    mac_rate = 2'b00;
    cycles(2);
    check(bond_rate_out == 2'b00, "R9 unbonded out", bond_rate_out, 0);

    // R10: reset mid-switch returns outputs to reset values
    mac_rate = 2'b10;
    cycles(8);
    rst_n = 1'b0;
    cycles(2);
    check(!pcs_rst && !pcs_clk_off && !g3_sel && pma_sw == 2'b00, "R10 reset mid-switch",
          {pcs_rst, pcs_clk_off, g3_sel}, 0);
    rst_n = 1'b1;
    mac_rate = 2'b00;
    cycles(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule